// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a target on a two-wire serial bus (I2C). An external controller uses it to read and write a small bank of 8-bit control registers. A fast system clock samples the bus lines. The block detects START, repeated START and STOP conditions. It answers a 7-bit device address whose two low bits come from strap pins. It keeps an internal register pointer that steps forward by itself after each byte. The block pulls SDA low through an open-drain output-enable and never drives it high. Every register is presented in parallel to the rest of the chip.

A write sends the device address with R/W=0, then a pointer byte, then any number of data bytes, and ends with STOP. A read first sets the pointer with a write-mode address and a pointer byte. The controller then issues a repeated START and the address with R/W=1, and the block returns registers from the pointer onward until the controller answers NACK.

The control is one state machine with these states:

- IDLE: waits for START.
- ADDR: shifts in the address byte.
- ADDR_ACK: drives the address ACK.
- PTR: shifts in the pointer byte.
- PTR_ACK: drives the pointer ACK.
- WDATA: shifts in a write byte.
- WDATA_ACK: drives the data ACK.
- RDATA: shifts out a read byte.
- RD_ACK: samples the controller's ACK or NACK.
- IGNORE: bus not addressed to this block.

Transitions:

- START in any state goes to ADDR. STOP in any state goes to IDLE.
- At the SCL fall after 8 address bits, a match goes to ADDR_ACK and a mismatch goes to IGNORE.
- At the next SCL fall, ADDR_ACK goes to RDATA for a read or to PTR for a write.
- PTR goes to PTR_ACK, and PTR_ACK goes to WDATA.
- WDATA and WDATA_ACK alternate.
- RDATA goes to RD_ACK. RD_ACK goes back to RDATA after an ACK, or to IGNORE after a NACK.

Top module: `i2c_reg_slave`

## Requirements
- R1: The device address is 7'b11000 followed by strap_a2 and then strap_a1, with strap_a1 as the least significant bit. The eighth bit is R/W (0 = write, 1 = read). On a match the block holds SDA low for the ninth clock.
- R2: On an address mismatch the block leaves SDA released, acknowledges nothing and changes no register until the next START.
- R3: In a write, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and then the pointer increments. Every pointer byte and data byte is acknowledged, and a burst runs until STOP.
- R4: Data moves most significant bit first in both directions.
- R5: After a repeated START and the address with R/W=1, the block sends the register at the current pointer.
- R6: A controller ACK on the ninth clock of a read byte increments the pointer, and the next register follows. A NACK leaves the pointer unchanged and SDA released until STOP.
- R7: START or STOP aborts any byte in progress without storing it. STOP returns the block to IDLE, and START begins a new address byte.
- R8: The block changes its SDA drive only while SCL is low.
- R9: 16 registers exist. A pointer at 16 or above reads 0x00, and writes there are acknowledged but discarded.
- R10: The pointer wraps from 255 to 0.
- R11: The pointer survives STOP, so a read without a pointer byte continues from it.
- R12: After reset all registers are 0x00, the pointer is 0 and SDA is released.
- R13: Register i appears on regs_o[8*i+7:8*i] and changes only through a bus write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_a2 | input | 1 | Device address bit 1 |
| strap_a1 | input | 1 | Device address bit 0 |
| regs_o | output | NREG*8 | All registers in parallel, register 0 in the low byte |

## Verification
A wrong state or bit count in this block shows up at the ports within one byte. The ninth-clock ACK goes missing or lands on the wrong clock, or the returned read data is shifted. A wrong pointer stays hidden until a later data byte is stored in the wrong slot of regs_o or a read returns the wrong register. That is why every burst is followed by a full compare of the parallel outputs and by read-backs that omit the pointer byte. A random mix of bursts, some starting beyond the implemented range or near the wrap point, is compared against a bench model of the bank and the pointer.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } i2cs_state_e;

    localparam logic [4:0] DEV_ID_HI = 5'b11000;
    localparam int         BYTE_W    = 8;

endpackage

// File: rtl/i2cs_line_cond.sv
module i2cs_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_p[STAGES-1];
            sda_q <= sda_p[STAGES-1];
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int AW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    input  logic [AW-1:0]      raddr,
    output logic [DW-1:0]      rdata,
    output logic [NREG*DW-1:0] regs_flat
);

    logic [DW-1:0] reg_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                reg_q[g] <= wdata;
            end
        end
        assign regs_flat[g*DW +: DW] = reg_q[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (raddr == AW'(i)) begin
                rdata = reg_q[i];
            end
        end
    end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2cs_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic                   strap_a2,
    input  logic                   strap_a1,
    output logic [NREG*BYTE_W-1:0] regs_o
);

    localparam int PW = 8;
    localparam int CW = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] FULL = CW'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2cs_state_e       state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] txsh_q;
    logic [PW-1:0]     ptr_q;
    logic              rw_q;
    logic              mack_q;
    logic [BYTE_W-1:0] rd_byte;
    logic              wr_en;
    logic              byte_full;
    logic              addr_hit;

    i2cs_line_cond #(.STAGES(STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_full = (cnt_q == FULL);
    assign addr_hit  = (shreg_q[7:1] == {DEV_ID_HI, strap_a2, strap_a1});
    assign wr_en     = (state_q == ST_WDATA) && scl_fall && byte_full
                       && !start_det && !stop_det;

    i2cs_regbank #(.NREG(NREG), .DW(BYTE_W), .AW(PW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .waddr     (ptr_q),
        .wdata     (shreg_q),
        .raddr     (ptr_q),
        .rdata     (rd_byte),
        .regs_flat (regs_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:      if (scl_fall && byte_full) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && byte_full) state_d = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_full) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_full) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) state_d = mack_q ? ST_RDATA : ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // datapath: bit counter, shifters, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            txsh_q  <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt_q <= '0;
        end else begin
            case (state_q)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                        cnt_q   <= cnt_q + 1'b1;
                    end
                    if (scl_fall && byte_full) begin
                        cnt_q <= '0;
                        if (state_q == ST_ADDR)  rw_q  <= shreg_q[0];
                        if (state_q == ST_PTR)   ptr_q <= shreg_q;
                        if (state_q == ST_WDATA) ptr_q <= ptr_q + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_q  <= '0;
                        txsh_q <= rd_byte;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) cnt_q <= cnt_q + 1'b1;
                    if (scl_fall) begin
                        if (byte_full)        cnt_q  <= '0;
                        else if (cnt_q != '0) txsh_q <= {txsh_q[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_s;
                        if (!sda_s) ptr_q <= ptr_q + 1'b1;
                    end
                    if (scl_fall) begin
                        txsh_q <= rd_byte;
                        cnt_q  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~txsh_q[BYTE_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
#(
    parameter int NREG = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_s,
    input logic                   start_det,
    input logic                   stop_det,
    input logic                   sda_oe,
    input logic                   wr_en,
    input logic [7:0]             ptr_q,
    input i2cs_state_e            state_q,
    input logic [NREG*BYTE_W-1:0] regs_o
);

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R8

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE) && !sda_oe); // R7

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR)); // R7

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr_q == $past(ptr_q) + 8'd1)); // R3

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o)); // R13

endmodule

bind i2c_reg_slave i2cs_checker #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .ptr_q     (ptr_q),
    .state_q   (state_q),
    .regs_o    (regs_o)
);

// File: tb/i2c_reg_slave_bench.sv
`timescale 1ns/1ps
module i2c_reg_slave_bench;

    localparam int NREG = 16;
    localparam int Q    = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         m_low = 1'b0;
    logic         a2 = 1'b1;
    logic         a1 = 1'b0;
    logic         sda_oe;
    logic [127:0] regs_o;
    logic         sda_line;

    int checks = 0;
    int failures = 0;
    int oe_viol = 0;
    int quiet_hits = 0;
    bit quiet = 1'b0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;

    logic [7:0] model [NREG];
    logic [7:0] ptr_m = 8'd0;
    logic [7:0] wbuf [8];

    always #2.5 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);

    i2c_reg_slave #(.NREG(NREG)) u_i2c_reg_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .strap_a2 (a2),
        .strap_a1 (a1),
        .regs_o   (regs_o)
    );

    // R8 monitor: drive changes only while SCL low; R2 quiet window
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl) oe_viol++;
        if (quiet && sda_oe) quiet_hits++;
        prev_oe <= sda_oe;
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input bit rw);
        return {5'b11000, a2, a1, rw};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] p);
        return (p < NREG) ? model[p[3:0]] : 8'h00;
    endfunction

    function automatic logic [127:0] model_flat();
        logic [127:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(2*Q);
        m_low = 1'b1; tick(2*Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(2*Q);
        m_low = 1'b0; tick(2*Q);
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic rd_byte(output logic [7:0] b, input bit give_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1'b1;
            tick(Q); b[i] = sda_line;
            tick(Q); scl = 1'b0;
            tick(Q);
        end
        m_low = give_ack; tick(Q);
        scl = 1'b1;       tick(2*Q);
        scl = 1'b0;       m_low = 1'b0;
        tick(Q);
    endtask

    task automatic write_burst(input logic [7:0] p, input int n);
        logic ak;
        bus_start();
        wr_byte(dev(1'b0), ak); check("R1 write address ack", ak, 1'b1);
        wr_byte(p, ak);         check("R3 pointer ack", ak, 1'b1);
        ptr_m = p;
        for (int k = 0; k < n; k++) begin
            wr_byte(wbuf[k], ak); check("R3 data ack", ak, 1'b1);
            if (ptr_m < NREG) model[ptr_m[3:0]] = wbuf[k];
            ptr_m = ptr_m + 8'd1;
        end
        bus_stop();
        check("R13 parallel registers", regs_o, model_flat());
    endtask

    task automatic read_burst(input bit set_p, input logic [7:0] p, input int n);
        logic ak;
        logic [7:0] v;
        if (set_p) begin
            bus_start();
            wr_byte(dev(1'b0), ak); check("R1 address ack", ak, 1'b1);
            wr_byte(p, ak);         check("R3 pointer ack", ak, 1'b1);
            ptr_m = p;
        end
        bus_start();
        wr_byte(dev(1'b1), ak); check("R5 read address ack", ak, 1'b1);
        for (int k = 0; k < n; k++) begin
            rd_byte(v, k < n - 1);
            check("R5 R4 read data", v, exp_rd(ptr_m));
            if (k < n - 1) ptr_m = ptr_m + 8'd1;
        end
        check("R6 release after NACK", sda_oe, 1'b0);
        bus_stop();
    endtask

    initial begin
        logic ak;
        void'($urandom(32'h1C2A5));
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        tick(5);
        check("R12 reset sda released", sda_oe, 1'b0);
        check("R12 reset registers", regs_o, 128'h0);
        rst_n = 1'b1;
        tick(10);

        // R3 burst example, then R5/R6 read back
        wbuf[0] = 8'h0E; wbuf[1] = 8'hD8; wbuf[2] = 8'hE1;
        write_burst(8'h00, 3);
        check("R3 reg2 value", regs_o[23:16], 8'hE1);
        read_burst(1'b1, 8'h00, 2);
        // R11 R6: pointer kept at 1 after NACK and STOP
        read_burst(1'b0, 8'h00, 1);

        // R2 address mismatch
        bus_start();
        quiet = 1'b1;
        wr_byte({5'b11000, ~a2, a1, 1'b0}, ak); check("R2 no ack on mismatch", ak, 1'b0);
        wr_byte(8'h00, ak); check("R2 ignored pointer", ak, 1'b0);
        wr_byte(8'h55, ak); check("R2 ignored data", ak, 1'b0);
        quiet = 1'b0;
        bus_stop();
        check("R2 sda never driven", quiet_hits, 0);
        check("R2 registers unchanged", regs_o, model_flat());

        // R7 STOP mid-byte
        bus_start();
        wr_byte(dev(1'b0), ak); wr_byte(8'h05, ak); ptr_m = 8'h05;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        check("R7 aborted byte not stored", regs_o, model_flat());
        // R11 read from retained pointer 5
        read_burst(1'b0, 8'h00, 1);

        // R7 repeated START mid-byte
        bus_start();
        wr_byte(dev(1'b0), ak); wr_byte(8'h06, ak);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        wr_byte(dev(1'b0), ak); check("R7 address after restart", ak, 1'b1);
        wr_byte(8'h07, ak);
        wr_byte(8'h3C, ak); model[7] = 8'h3C; ptr_m = 8'h08;
        bus_stop();
        check("R7 restart result", regs_o, model_flat());

        // R9 out-of-range pointer
        wbuf[0] = 8'h99; wbuf[1] = 8'h77;
        write_burst(8'h10, 2);
        check("R9 out-of-range write discarded", regs_o, model_flat());
        read_burst(1'b1, 8'h20, 1);
        read_burst(1'b1, 8'h0F, 2);

        // R10 wrap
        wbuf[0] = 8'hAA; wbuf[1] = 8'h5B;
        write_burst(8'hFF, 2);
        check("R10 wrap to reg0", regs_o[7:0], 8'h5B);

        // R1 strap change
        a2 = 1'b0; a1 = 1'b1;
        bus_start();
        wr_byte(8'b1100_0100, ak); check("R1 old address refused", ak, 1'b0);
        bus_stop();
        read_burst(1'b1, 8'h00, 2);

        // random bursts
        for (int it = 0; it < 12; it++) begin
            int n;
            logic [7:0] p;
            n = 1 + int'($urandom % 5);
            p = ($urandom % 4 == 0) ? 8'(8'hF0 + ($urandom % 16)) : 8'($urandom % 20);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            write_burst(p, n);
            read_burst(1'b1, 8'($urandom % 18), 1 + int'($urandom % 4));
        end

        check("R8 drive changed while SCL high", oe_viol, 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule